// File: doc/BRIEF.md
# Buffered PWM Channel with 9/10/11-Bit Cycle Length

This block makes one pulse-width-modulated output from a free-running timebase counter that other channels may share. A two-bit length field picks a cycle of 2^N counts, with N equal to 9, 10 or 11. Only the low N bits of the counter are compared. The output rises when those bits reach the active duty value. It falls when the N-bit field wraps to zero.

Software sets the duty value through a byte-wide register port. Two 16-bit registers sit behind the same two byte addresses: the active compare register and a shadow reload register. A select bit in the control byte chooses which one is reached. The reload value moves into the compare register at every wrap, so a new duty value takes effect only on a cycle boundary. A write to the low duty byte turns the compare enable off and a write to the high byte turns it on. Software therefore writes the low byte first, and the half-written value never drives the output. Sticky flags record cycle wraps and compare matches.

Top module: `nbit_pwm_channel`

## Requirements
- R1: After a synchronous active-low reset, the compare and reload registers are 0 and the enable is 0. The length field reads 01, both flags are clear, and `pwm_out` is low.
- R2: Control byte (address 2) bits [1:0] set N: 01 gives 9, 10 gives 10 and 11 gives 11. The cycle is 2^N timebase steps. Writing 00 to this field leaves the length unchanged.
- R3: With the enable on and duty value D, `pwm_out` is high while the counter's low N bits are at least D. It rises on the step where they reach D and falls on the step where they wrap to 0. The high time is 2^N − D steps, and D = 0 keeps the output high.
- R4: At each wrap the reload register is copied into the compare register. A software write to the compare register on the wrap step loses to this copy.
- R5: Control bit 2 selects the target of addresses 0 (low byte) and 1 (high byte): 1 reaches the reload register and 0 reaches the compare register. Reads and writes both follow it.
- R6: Any write to address 0 clears the enable and any write to address 1 sets it, whatever the value of bit 2. The enable reads back on control bit 6.
- R7: While the enable is 0, `pwm_out` stays low for whole cycles.
- R8: Control bit 4 is a sticky wrap flag, set on every wrap. Writing 0 clears it and writing 1 has no effect. A wrap on the same step as a clearing write leaves it set.
- R9: Control bit 5 is a sticky match flag. It is set on each compare match only when control bit 3 is 1. Writing 0 clears it and writing 1 has no effect.
- R10: Only the low N bits of the duty value take part in the compare. Bits above N have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_count | input | CNT_W | Current value of the shared timebase counter |
| tb_step | input | 1 | High when the counter advances by one at this edge |
| reg_addr | input | 2 | Register address: 0 duty low byte, 1 duty high byte, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The bench uses the default 16-bit timebase and duty width. With these widths, duty values carrying set bits above N can be written, which tests that the compare ignores them. All three cycle lengths are run, up to the full 2048-step period, and the output is compared against its expected level at every step of a whole cycle. Directed tests place register writes exactly on the wrap step to check the ordering of the reload copy and of the flag clears.

// File: rtl/pwm_chan_pkg.sv
// Shared constants and helpers for the buffered PWM channel.
package pwm_chan_pkg;
    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int LEN_BASE = 8;

    typedef enum logic [1:0] {
        ADDR_DUTY_LO = 2'd0,
        ADDR_DUTY_HI = 2'd1,
        ADDR_CTRL    = 2'd2
    } reg_addr_e;

    // Control byte bit positions
    localparam int CB_LEN_LO = 0;
    localparam int CB_LEN_HI = 1;
    localparam int CB_SEL    = 2;
    localparam int CB_MFEN   = 3;
    localparam int CB_OVF    = 4;
    localparam int CB_MATCH  = 5;
    localparam int CB_EN     = 6;

    // Mask that keeps the low N bits, N = LEN_BASE + length code
    function automatic logic [CNT_W-1:0] len_mask(input logic [1:0] len);
        return CNT_W'((32'd1 << (32'(len) + 32'(LEN_BASE))) - 32'd1);
    endfunction
endpackage

// File: rtl/pwm_sticky_flag.sv
// Sticky status bit: set by hardware, cleared by a software write of 0.
// Assumes: set and clear may coincide; the set wins.
module pwm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_clr,
    output logic flag
);
    // Hold the flag, set before clear
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hw_set) flag <= 1'b1;
        else if (sw_clr) flag <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hw_set) |=> !flag);
endmodule

// File: rtl/pwm_cycle_detect.sv
// Finds the wrap and match events for the step taken at this edge.
// Looks one count ahead so the registered output lines up with the counter.
// Assumes: the counter advances by exactly one when tb_step is high.
module pwm_cycle_detect
    import pwm_chan_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [W-1:0] tb_count,
    input  logic         tb_step,
    input  logic [1:0]   len_sel,
    input  logic [W-1:0] cmp_val,
    input  logic [W-1:0] reload_val,
    input  logic         cmp_en,
    output logic         wrap_ev,
    output logic         match_ev
);
    logic [W-1:0] mask;
    logic [W-1:0] next_cnt;
    logic [W-1:0] eff_cmp;

    // Event decode for the coming step
    always_comb begin
        mask     = W'(len_mask(len_sel));
        next_cnt = tb_count + W'(1);
        wrap_ev  = tb_step && ((tb_count & mask) == mask);
        eff_cmp  = wrap_ev ? reload_val : cmp_val;
        match_ev = tb_step && cmp_en && ((next_cnt & mask) == (eff_cmp & mask));
    end
endmodule

// File: rtl/pwm_duty_regs.sv
// Active compare register, shadow reload register and compare enable.
// Byte writes reach either register through the access select; the reload
// copy at a wrap overrides a same-step compare write.
module pwm_duty_regs
    import pwm_chan_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_lo,
    input  logic         wr_hi,
    input  logic [7:0]   wdata,
    input  logic         sel_reload,
    input  logic         wrap_ev,
    output logic [W-1:0] cmp_q,
    output logic [W-1:0] reload_q,
    output logic         en_q
);
    // Register updates: byte writes first, then the wrap copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            reload_q <= '0;
        end else begin
            if (wr_lo) begin
                if (sel_reload) reload_q[7:0] <= wdata;
                else            cmp_q[7:0]    <= wdata;
            end
            if (wr_hi) begin
                if (sel_reload) reload_q[W-1:8] <= wdata[W-9:0];
                else            cmp_q[W-1:8]    <= wdata[W-9:0];
            end
            if (wrap_ev) cmp_q <= reload_q;
        end
    end

    // Enable follows the byte written last
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_lo) en_q <= 1'b0;
        else if (wr_hi) en_q <= 1'b1;
    end

    assert_reload_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_ev |=> (cmp_q == $past(reload_q)));
    assert_lo_clears_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> !en_q);
    assert_hi_sets_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> en_q);
endmodule

// File: rtl/pwm_ctrl_reg.sv
// Control byte: cycle length, access select, match-flag enable and the two
// sticky flags. A length code of 00 is refused and the old length is kept.
module pwm_ctrl_reg
    import pwm_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       wrap_ev,
    input  logic       match_ev,
    output logic [1:0] len_sel,
    output logic       sel_reload,
    output logic       mflag_en,
    output logic       wrap_flag,
    output logic       match_flag
);
    // Configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_sel    <= 2'b01;
            sel_reload <= 1'b0;
            mflag_en   <= 1'b0;
        end else if (wr_ctrl) begin
            if (wdata[CB_LEN_HI:CB_LEN_LO] != 2'b00)
                len_sel <= wdata[CB_LEN_HI:CB_LEN_LO];
            sel_reload <= wdata[CB_SEL];
            mflag_en   <= wdata[CB_MFEN];
        end
    end

    pwm_sticky_flag u_wrap_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (wrap_ev),
        .sw_clr (wr_ctrl && !wdata[CB_OVF]),
        .flag   (wrap_flag)
    );

    pwm_sticky_flag u_match_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (match_ev && mflag_en),
        .sw_clr (wr_ctrl && !wdata[CB_MATCH]),
        .flag   (match_flag)
    );

    assert_len_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len_sel != 2'b00);
    assert_match_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mflag_en && !match_flag) |=> !match_flag);
endmodule

// File: rtl/nbit_pwm_channel.sv
// Top of the buffered PWM channel: register decode, read mux and the
// output flop. Assumes tb_count is shared and advances only on tb_step.
module nbit_pwm_channel
    import pwm_chan_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tb_count,
    input  logic          tb_step,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          pwm_out
);
    logic          wr_lo, wr_hi, wr_ctrl;
    logic [1:0]    len_sel;
    logic          sel_reload, mflag_en, wrap_flag, match_flag;
    logic [CW-1:0] cmp_q, reload_q, sel_val;
    logic          en_q, wrap_ev, match_ev;

    // Address decode for writes
    always_comb begin
        wr_lo   = reg_wr && (reg_addr == ADDR_DUTY_LO);
        wr_hi   = reg_wr && (reg_addr == ADDR_DUTY_HI);
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    end

    pwm_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wdata      (reg_wdata),
        .wrap_ev    (wrap_ev),
        .match_ev   (match_ev),
        .len_sel    (len_sel),
        .sel_reload (sel_reload),
        .mflag_en   (mflag_en),
        .wrap_flag  (wrap_flag),
        .match_flag (match_flag)
    );

    pwm_duty_regs #(.W(CW)) u_duty (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (reg_wdata),
        .sel_reload (sel_reload),
        .wrap_ev    (wrap_ev),
        .cmp_q      (cmp_q),
        .reload_q   (reload_q),
        .en_q       (en_q)
    );

    pwm_cycle_detect #(.W(CW)) u_detect (
        .tb_count   (tb_count),
        .tb_step    (tb_step),
        .len_sel    (len_sel),
        .cmp_val    (cmp_q),
        .reload_val (reload_q),
        .cmp_en     (en_q),
        .wrap_ev    (wrap_ev),
        .match_ev   (match_ev)
    );

    // Read mux over the selected duty register and the control byte
    always_comb begin
        sel_val = sel_reload ? reload_q : cmp_q;
        unique case (reg_addr)
            ADDR_DUTY_LO: reg_rdata = sel_val[7:0];
            ADDR_DUTY_HI: reg_rdata = sel_val[15:8];
            ADDR_CTRL:    reg_rdata = {1'b0, en_q, match_flag, wrap_flag,
                                       mflag_en, sel_reload, len_sel};
            default:      reg_rdata = '0;
        endcase
    end

    // Output flop: match raises, wrap lowers, disable forces low
    always_ff @(posedge clk) begin
        if (!rst_n)        pwm_out <= 1'b0;
        else if (!en_q)    pwm_out <= 1'b0;
        else if (match_ev) pwm_out <= 1'b1;
        else if (wrap_ev)  pwm_out <= 1'b0;
    end

    assert_match_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_ev |=> pwm_out);
    assert_wrap_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_ev && !match_ev) |=> !pwm_out);
    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !pwm_out);
endmodule

// File: tb/nbit_pwm_channel_bench.sv
module nbit_pwm_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt;
    logic        step = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        pwm;
    int          total = 0;
    int          bad = 0;
    logic [1:0]  cur_len = 2'b01;

    always #5 clk = ~clk;

    // Bench-owned shared timebase
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= cnt + 16'd1;
    end

    nbit_pwm_channel u_nbit_pwm_channel (
        .clk(clk), .rst_n(rst_n), .tb_count(cnt), .tb_step(step),
        .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .pwm_out(pwm)
    );

    // {len, duty}
    localparam logic [17:0] VEC [6] = '{
        {2'b01, 16'h0100}, {2'b01, 16'h0000}, {2'b10, 16'h0155},
        {2'b11, 16'h07FF}, {2'b11, 16'hF805}, {2'b10, 16'h03FF}
    };

    function automatic int mask_of(input logic [1:0] l);
        return (1 << (8 + int'(l))) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_low(input int v);
        forever begin
            @(negedge clk);
            if ((int'(cnt) & mask_of(cur_len)) == v) break;
        end
    endtask

    // Run one full cycle from low bits 0; return mismatches and high count
    task automatic run_cycle(input int d, output int errs, output int highs);
        int p;
        p = mask_of(cur_len) + 1;
        errs = 0; highs = 0;
        wait_low(0);
        for (int i = 0; i < p; i++) begin
            if (i != 0) @(negedge clk);
            if (pwm) highs++;
            if (pwm != (i >= d)) errs++;
        end
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] r, r2;
        int errs, highs, d, p;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pwm == 1'b0, "R1 out", int'(pwm), 0);
        rd_reg(2'd2, r);
        chk(r == 8'h01, "R1 ctrl", r, 8'h01);
        rd_reg(2'd0, r); rd_reg(2'd1, r2);
        chk({r2, r} == 16'h0, "R1 compare", {r2, r}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 access select: reload written, compare untouched until wrap
        wr_reg(2'd2, 8'h30 | 8'h04 | 8'h01);
        wr_reg(2'd0, 8'h23); wr_reg(2'd1, 8'h01);
        rd_reg(2'd0, r); rd_reg(2'd1, r2);
        chk({r2, r} == 16'h0123, "R5 reload read", {r2, r}, 16'h0123);
        @(negedge clk);
        wr_reg(2'd2, 8'h30 | 8'h01);
        rd_reg(2'd0, r); rd_reg(2'd1, r2);
        chk({r2, r} == 16'h0000, "R5 compare read", {r2, r}, 0);
        wait_low(3);
        rd_reg(2'd0, r); rd_reg(2'd1, r2);
        chk({r2, r} == 16'h0123, "R4 wrap copy", {r2, r}, 16'h0123);

        // R2 R3 R10 vector walk
        foreach (VEC[k]) begin
            cur_len = VEC[k][17:16];
            @(negedge clk);
            wr_reg(2'd2, 8'h30 | 8'h04 | {6'd0, cur_len});
            wr_reg(2'd0, VEC[k][7:0]); wr_reg(2'd1, VEC[k][15:8]);
            wr_reg(2'd2, 8'h30 | {6'd0, cur_len});
            p = mask_of(cur_len) + 1;
            repeat (2 * p + 4) @(negedge clk);
            d = int'(VEC[k][15:0]) & mask_of(cur_len);
            run_cycle(d, errs, highs);
            chk(errs == 0, "R3 R10 step-by-step level", errs, 0);
            chk(highs == p - d, "R2 R3 high time", highs, p - d);
        end

        // R2 length code 00 refused (current length 10)
        @(negedge clk);
        wr_reg(2'd2, 8'h30);
        rd_reg(2'd2, r);
        chk(r[1:0] == 2'b10, "R2 len 00 ignored", r[1:0], 2'b10);

        // R6 enable follows byte writes, also with select set to reload
        @(negedge clk);
        wr_reg(2'd2, 8'h30 | 8'h04 | 8'h02);
        wr_reg(2'd0, 8'h42);
        rd_reg(2'd2, r);
        chk(r[6] == 1'b0, "R6 low write clears", r[6], 0);
        @(negedge clk);
        wr_reg(2'd1, 8'h00);
        rd_reg(2'd2, r);
        chk(r[6] == 1'b1, "R6 high write sets", r[6], 1);

        // R4 wrap copy beats a same-step compare write
        @(negedge clk);
        wr_reg(2'd2, 8'h30 | 8'h02);
        wait_low(mask_of(2'b10));
        wr_reg(2'd0, 8'h99);
        rd_reg(2'd0, r);
        chk(r == 8'h42, "R4 wrap priority", r, 8'h42);
        @(negedge clk);
        wr_reg(2'd0, 8'h77);
        rd_reg(2'd0, r);
        chk(r == 8'h77, "R5 compare write", r, 8'h77);

        // R7 disabled output stays low for a whole cycle
        run_cycle(1 << 20, errs, highs);
        chk(highs == 0, "R7 disabled low", highs, 0);

        // R8 wrap flag set, cleared by 0, kept by wrap on same step
        rd_reg(2'd2, r);
        chk(r[4] == 1'b1, "R8 flag set", r[4], 1);
        wait_low(5);
        wr_reg(2'd2, 8'h20 | 8'h02);
        rd_reg(2'd2, r);
        chk(r[4] == 1'b0, "R8 flag cleared", r[4], 0);
        wait_low(mask_of(2'b10));
        wr_reg(2'd2, 8'h20 | 8'h02);
        rd_reg(2'd2, r);
        chk(r[4] == 1'b1, "R8 set wins", r[4], 1);

        // R9 match flag gated by its enable
        wait_low(5);
        wr_reg(2'd2, 8'h10 | 8'h02);
        wr_reg(2'd1, 8'h00);
        run_cycle(int'(16'h0077), errs, highs);
        rd_reg(2'd2, r);
        chk(r[5] == 1'b0, "R9 gated off", r[5], 0);
        @(negedge clk);
        wr_reg(2'd2, 8'h30 | 8'h08 | 8'h02);
        run_cycle(int'(16'h0077), errs, highs);
        rd_reg(2'd2, r);
        chk(r[5] == 1'b1, "R9 flag set", r[5], 1);

        finish_run();
    end
endmodule